// File: doc/BRIEF.md
# Keyed-Sequence 64-bit Watchdog Timer

This block is a register-mapped watchdog built on a 64-bit up-counter. The counter is held as two 32-bit halves, and the compare limit is held as two 32-bit halves. Software sets the limit, picks the counting mode and takes both halves out of reset through a 32-bit word interface with separate write and read strobes. It then arms the watchdog by writing an ordered pair of 16-bit keys into a control word.

Once the block is armed, every configuration register is frozen. Software must repeat the same two-key exchange before the count reaches the limit. That exchange restarts the count from zero. If the count reaches the limit, or if software writes a key that is out of order or unknown, the block sets a sticky expiry flag and drives a one-cycle reset request. After that it accepts nothing until the system reset.

Top module: `keyseq_wdog`

## Requirements
- R1: After reset, every readable register returns zero except the identity word at offset 0x00, which returns the ID_VALUE parameter, and `wd_rst` is low.
- R2: The count advances by one per clock only when all three of these hold: the timer control bits [7:6] (offset 0x20) are 1 (one-shot) or 2 (continuous); the global control bits [3:2] (offset 0x24) equal 2; and both half-release bits [1:0] are set. A half whose release bit is clear is held at zero.
- R3: The count is the high half (offset 0x14) above the low half (offset 0x10). The low half carries into the high half. A read strobe returns the live value at the next clock edge.
- R4: In one-shot mode the count stops once it reaches the 64-bit limit (offsets 0x18 low, 0x1C high). In continuous mode it runs past the limit.
- R5: In idle, a control write (offset 0x28) carrying key 0xA5C6 in bits [31:16] with bit 14 set enters pre-active. A following write of key 0xDA7E with bit 14 set enters active and clears the count. Bit 14 reads 1 in every armed state.
- R6: In idle, a control write carrying any other value changes nothing and raises no reset.
- R7: From pre-active on, writes to the count, limit, timer control and global control registers are ignored.
- R8: In active or service, once the count is at or above the limit, `wd_rst` pulses. This happens L+1 cycles after the arming write for a limit L, or after one cycle for L = 0. Pre-active never expires.
- R9: In active, key 0xA5C6 enters service. A following 0xDA7E returns to active with the count restarted from zero.
- R10: In any armed state, a key other than the one expected next fires `wd_rst` in the cycle after the write. This covers a repeated 0xA5C6, a lone 0xDA7E, an unknown key, and in pre-active a 0xDA7E with bit 14 clear.
- R11: `wd_rst` is high for exactly one cycle. Bit 15 of the control word then reads 1 and stays set, and later keys raise no further pulse until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; data is valid after the next edge |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wd_rst | output | 1 | One-cycle reset request |

## Verification
A write takes effect at the clock edge that samples it. Read data appears one edge after the read strobe and shows the count as it stood before that edge's increment. A key fault shows on `wd_rst` in the cycle straight after the faulty write's edge. An expiry shows exactly L+1 edges after the arming write. The bench therefore drives and samples only on falling edges. For each limit in a small sweep, it steps one edge at a time and demands the pulse on exactly the computed edge and on no other. Count results are derived arithmetically from the number of enabled edges between the strobes, over every combination of mode and release bits.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NHALF  = 2;
  localparam int unsigned CNT_W  = NHALF * WORD_W;

  localparam int unsigned OFF_ID     = 'h00;
  localparam int unsigned OFF_EMU    = 'h04;
  localparam int unsigned OFF_CNT_LO = 'h10;
  localparam int unsigned OFF_CNT_HI = 'h14;
  localparam int unsigned OFF_PER_LO = 'h18;
  localparam int unsigned OFF_PER_HI = 'h1C;
  localparam int unsigned OFF_TCTL   = 'h20;
  localparam int unsigned OFF_GCTL   = 'h24;
  localparam int unsigned OFF_WCTL   = 'h28;

  localparam int unsigned KEY_LSB  = 16;
  localparam int unsigned KEY_W    = 16;
  localparam int unsigned ENA_BIT  = 14;
  localparam int unsigned FLAG_BIT = 15;

  localparam logic [KEY_W-1:0] KEY_ARM_DEF = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_RUN_DEF = 16'hDA7E;

  localparam logic [1:0] TM_OFF     = 2'd0;
  localparam logic [1:0] TM_ONESHOT = 2'd1;
  localparam logic [1:0] TM_CONT    = 2'd2;
  localparam logic [1:0] WD_SELECT  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ACT   = 3'd2,
    ST_SVC   = 3'd3,
    ST_FIRED = 3'd4
  } kwd_state_e;
endpackage

// File: rtl/kwd_cfg_regs.sv
`timescale 1ns/1ps
module kwd_cfg_regs
  import kwd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                locked,
  input  logic [NHALF-1:0]    per_we,
  input  logic                tctl_we,
  input  logic                gctl_we,
  input  logic [WORD_W-1:0]   wr_word,
  output logic [CNT_W-1:0]    period,
  output logic [1:0]          tmode,
  output logic [1:0]          wmode,
  output logic [NHALF-1:0]    half_rel
);
  logic [1:0]       tmode_q, tmode_d;
  logic [1:0]       wmode_q, wmode_d;
  logic [NHALF-1:0] rel_q, rel_d;

  for (genvar h = 0; h < NHALF; h++) begin : g_per
    logic [WORD_W-1:0] per_q, per_d;
    always_comb begin
      per_d = per_q;
      if (per_we[h] && !locked) per_d = wr_word;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) per_q <= '0;
      else        per_q <= per_d;
    end
    assign period[h*WORD_W +: WORD_W] = per_q;
  end

  always_comb begin
    tmode_d = tmode_q;
    wmode_d = wmode_q;
    rel_d   = rel_q;
    if (tctl_we && !locked) tmode_d = wr_word[7:6];
    if (gctl_we && !locked) begin
      wmode_d = wr_word[3:2];
      rel_d   = wr_word[NHALF-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmode_q <= '0;
      wmode_q <= '0;
      rel_q   <= '0;
    end else begin
      tmode_q <= tmode_d;
      wmode_q <= wmode_d;
      rel_q   <= rel_d;
    end
  end

  assign tmode    = tmode_q;
  assign wmode    = wmode_q;
  assign half_rel = rel_q;

  // R7: the locked configuration cannot move
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(period) && $stable(tmode) && $stable(wmode) && $stable(half_rel)));
endmodule

// File: rtl/kwd_counter.sv
`timescale 1ns/1ps
module kwd_counter
  import kwd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                oneshot,
  input  logic                clear,
  input  logic [NHALF-1:0]    ld_we,
  input  logic [NHALF-1:0]    half_rel,
  input  logic [WORD_W-1:0]   ld_word,
  input  logic [CNT_W-1:0]    period,
  output logic [CNT_W-1:0]    count
);
  logic             step;
  logic [NHALF-1:0] carry;

  assign step     = run_en && !(oneshot && (count >= period));
  assign carry[0] = step;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [WORD_W-1:0] half_q, half_d;
    always_comb begin
      if (clear || !half_rel[h]) half_d = '0;
      else if (ld_we[h])         half_d = ld_word;
      else if (carry[h])         half_d = half_q + 1'b1;
      else                       half_d = half_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= '0;
      else        half_q <= half_d;
    end
    assign count[h*WORD_W +: WORD_W] = half_q;
    if (h < NHALF-1) begin : g_carry
      assign carry[h+1] = carry[h] && (&half_q);
    end
  end

  // R2: without enable, load or clear the count holds
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clear && (ld_we == '0) && (&half_rel)) |=> $stable(count));
  // R4: one-shot count parks at the limit
  a_r4_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && (count >= period) && !clear && (ld_we == '0) && (&half_rel)) |=> $stable(count));
  // R9: a restart leaves the count at zero
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/kwd_key_fsm.sv
`timescale 1ns/1ps
module kwd_key_fsm
  import kwd_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_ARM = KEY_ARM_DEF,
  parameter logic [KEY_W-1:0] KEY_RUN = KEY_RUN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [KEY_W-1:0]  ctl_key,
  input  logic              ctl_en,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  period,
  output logic              armed,
  output logic              restart,
  output logic              fire_q,
  output logic              flag_q
);
  kwd_state_e state_q, state_d;
  logic       fire, flag_d;
  logic       key_arm, key_run, expired;

  assign key_arm = (ctl_key == KEY_ARM);
  assign key_run = (ctl_key == KEY_RUN);
  assign expired = (count >= period);

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    restart = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ctl_we && key_arm && ctl_en) state_d = ST_PRE;
      ST_PRE: begin
        if (ctl_we) begin
          if (key_run && ctl_en) begin
            state_d = ST_ACT;
            restart = 1'b1;
          end else fire = 1'b1;
        end
      end
      ST_ACT: begin
        if (expired) fire = 1'b1;
        else if (ctl_we) begin
          if (key_arm) state_d = ST_SVC;
          else         fire = 1'b1;
        end
      end
      ST_SVC: begin
        if (expired) fire = 1'b1;
        else if (ctl_we) begin
          if (key_run) begin
            state_d = ST_ACT;
            restart = 1'b1;
          end else fire = 1'b1;
        end
      end
      default: ;
    endcase
    if (fire) state_d = ST_FIRED;
    flag_d = flag_q | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fire_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire;
      flag_q  <= flag_d;
    end
  end

  assign armed = (state_q != ST_IDLE);

  // R11: pulse lasts one cycle, flag never clears
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
  // R8: an expiry in a running state is answered next cycle
  a_r8_expiry_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (((state_q == ST_ACT) || (state_q == ST_SVC)) && (count >= period)) |=> (fire_q && flag_q));
  // R10: in active only the first key is legal
  a_r10_bad_key_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (state_q == ST_ACT) && (ctl_key != KEY_ARM)) |=> fire_q);
  // R6: idle leaves only on a proper arming write
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !(ctl_we && (ctl_key == KEY_ARM) && ctl_en))
      |=> ((state_q == ST_IDLE) && !fire_q));
endmodule

// File: rtl/keyseq_wdog.sv
`timescale 1ns/1ps
module keyseq_wdog
  import kwd_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 6,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] ID_VALUE    = 32'h4B57_0001,
  parameter logic [KEY_W-1:0]  KEY_ARM     = KEY_ARM_DEF,
  parameter logic [KEY_W-1:0]  KEY_RUN     = KEY_RUN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              wd_rst
);
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_sys_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sys_n = rsync_q[SYNC_STAGES-1];

  logic [NHALF-1:0] per_we, cnt_we;
  logic             tctl_we, gctl_we, wctl_we;

  assign per_we[0] = wr_en && (addr == ADDR_W'(OFF_PER_LO));
  assign per_we[1] = wr_en && (addr == ADDR_W'(OFF_PER_HI));
  assign cnt_we[0] = wr_en && (addr == ADDR_W'(OFF_CNT_LO));
  assign cnt_we[1] = wr_en && (addr == ADDR_W'(OFF_CNT_HI));
  assign tctl_we   = wr_en && (addr == ADDR_W'(OFF_TCTL));
  assign gctl_we   = wr_en && (addr == ADDR_W'(OFF_GCTL));
  assign wctl_we   = wr_en && (addr == ADDR_W'(OFF_WCTL));

  logic [CNT_W-1:0] period, count;
  logic [1:0]       tmode, wmode;
  logic [NHALF-1:0] half_rel;
  logic             armed, restart, fire_q, flag_q;
  logic             run_en, oneshot;

  kwd_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .locked   (armed),
    .per_we   (per_we),
    .tctl_we  (tctl_we),
    .gctl_we  (gctl_we),
    .wr_word  (wdata),
    .period   (period),
    .tmode    (tmode),
    .wmode    (wmode),
    .half_rel (half_rel)
  );

  assign oneshot = (tmode == TM_ONESHOT);
  assign run_en  = ((tmode == TM_ONESHOT) || (tmode == TM_CONT)) &&
                   (wmode == WD_SELECT) && (&half_rel);

  kwd_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .run_en   (run_en),
    .oneshot  (oneshot),
    .clear    (restart),
    .ld_we    (cnt_we & {NHALF{!armed}}),
    .half_rel (half_rel),
    .ld_word  (wdata),
    .period   (period),
    .count    (count)
  );

  kwd_key_fsm #(
    .KEY_ARM (KEY_ARM),
    .KEY_RUN (KEY_RUN)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sys_n),
    .ctl_we  (wctl_we),
    .ctl_key (wdata[KEY_LSB +: KEY_W]),
    .ctl_en  (wdata[ENA_BIT]),
    .count   (count),
    .period  (period),
    .armed   (armed),
    .restart (restart),
    .fire_q  (fire_q),
    .flag_q  (flag_q)
  );

  logic [WORD_W-1:0] rd_mux, rdata_q, rdata_d;

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFF_ID):     rd_mux = ID_VALUE;
      ADDR_W'(OFF_CNT_LO): rd_mux = count[0 +: WORD_W];
      ADDR_W'(OFF_CNT_HI): rd_mux = count[WORD_W +: WORD_W];
      ADDR_W'(OFF_PER_LO): rd_mux = period[0 +: WORD_W];
      ADDR_W'(OFF_PER_HI): rd_mux = period[WORD_W +: WORD_W];
      ADDR_W'(OFF_TCTL):   rd_mux[7:6] = tmode;
      ADDR_W'(OFF_GCTL):   rd_mux[3:0] = {wmode, half_rel};
      ADDR_W'(OFF_WCTL): begin
        rd_mux[FLAG_BIT] = flag_q;
        rd_mux[ENA_BIT]  = armed;
      end
      default:             rd_mux = '0;
    endcase
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign rdata  = rdata_q;
  assign wd_rst = fire_q;

  // R1: no reset request can leave the block before an armed state exists
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_sys_n)
    !armed |=> !wd_rst);
  // R3: a read strobe delivers the live count one edge later
  a_r3_count_readback: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (rd_en && (addr == ADDR_W'(OFF_CNT_LO))) |=> (rdata == $past(count[0 +: WORD_W])));
endmodule

// File: tb/keyseq_wdog_tb.sv
`timescale 1ns/1ps
module keyseq_wdog_tb;
  localparam logic [5:0] A_ID = 6'h00, A_CLO = 6'h10, A_CHI = 6'h14, A_PLO = 6'h18,
                         A_PHI = 6'h1C, A_TC = 6'h20, A_GC = 6'h24, A_WC = 6'h28;
  localparam logic [31:0] ARM_EN = 32'hA5C6_4000, RUN_EN = 32'hDA7E_4000;
  localparam logic [31:0] ID_EXP = 32'h4B57_0001;

  logic        clk, rst_n, wr_en, rd_en, wd_rst;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  int n_chk, n_err;

  keyseq_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wd_rst(wd_rst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] plo, input logic [31:0] phi, input logic [31:0] tc);
    wr(A_GC, 32'h0000_000B);
    wr(A_PLO, plo);
    wr(A_PHI, phi);
    wr(A_TC, tc);
  endtask

  task automatic bad_case(input int c);
    logic [31:0] v;
    do_reset();
    setup(32'd1000, 32'd0, 32'h80);
    case (c)
      0: begin wr(A_WC, ARM_EN); end
      1: begin wr(A_WC, ARM_EN); end
      2: begin wr(A_WC, ARM_EN); end
      3: begin wr(A_WC, ARM_EN); wr(A_WC, RUN_EN); end
      4: begin wr(A_WC, ARM_EN); wr(A_WC, RUN_EN); end
      5: begin wr(A_WC, ARM_EN); wr(A_WC, RUN_EN); wr(A_WC, ARM_EN); end
      default: begin wr(A_WC, ARM_EN); wr(A_WC, RUN_EN); wr(A_WC, ARM_EN); end
    endcase
    chk("R10 no pulse before fault", wd_rst, 1'b0);
    case (c)
      0: wr(A_WC, 32'h0000_4000);
      1: wr(A_WC, ARM_EN);
      2: wr(A_WC, 32'hDA7E_0000);
      3: wr(A_WC, RUN_EN);
      4: wr(A_WC, 32'h0000_4000);
      5: wr(A_WC, ARM_EN);
      default: wr(A_WC, 32'h1234_4000);
    endcase
    chk($sformatf("R10 fault case %0d pulse", c), wd_rst, 1'b1);
    @(negedge clk);
    chk("R11 pulse one cycle", wd_rst, 1'b0);
    rd(A_WC, v);
    chk("R11 flag set", v, 32'h0000_C000);
    wr(A_WC, ARM_EN);
    wr(A_WC, RUN_EN);
    for (int k = 0; k < 3; k++) begin
      chk("R11 no second pulse", wd_rst, 1'b0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    n_chk = 0; n_err = 0;
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 wd_rst low", wd_rst, 1'b0);
    rd(A_ID, v);  chk("R1 id word", v, ID_EXP);
    rd(A_CLO, v); chk("R1 count lo", v, 0);
    rd(A_CHI, v); chk("R1 count hi", v, 0);
    rd(A_PLO, v); chk("R1 limit lo", v, 0);
    rd(A_TC, v);  chk("R1 timer ctl", v, 0);
    rd(A_GC, v);  chk("R1 global ctl", v, 0);
    rd(A_WC, v);  chk("R1 wd ctl", v, 0);

    // R2 sweep of all global-control and timer-mode combinations, 4 enabled edges
    wr(A_PHI, 32'd1);
    for (int g = 0; g < 16; g++) begin
      for (int t = 0; t < 4; t++) begin
        wr(A_GC, 32'(g));
        wr(A_CLO, 32'd0);
        wr(A_CHI, 32'd0);
        wr(A_TC, 32'(t) << 6);
        repeat (3) @(negedge clk);
        wr(A_TC, 32'd0);
        rd(A_CLO, v);
        chk($sformatf("R2 g=%0d t=%0d", g, t), v,
            (((g >> 2) == 2) && ((g & 3) == 3) && (t == 1 || t == 2)) ? 32'd4 : 32'd0);
      end
    end

    // R3 carry between halves and live read
    wr(A_GC, 32'h0B);
    wr(A_CLO, 32'hFFFF_FFFE);
    wr(A_CHI, 32'd5);
    wr(A_TC, 32'h80);
    repeat (2) @(negedge clk);
    wr(A_TC, 32'd0);
    rd(A_CLO, v);  chk("R3 carry low half", v, 32'd1);
    rd(A_CHI, v);  chk("R3 carry high half", v, 32'd6);
    wr(A_TC, 32'h80);
    rd(A_CLO, v);
    rd(A_CLO, v2);
    chk("R3 live read advances by one", v2 - v, 32'd1);
    wr(A_TC, 32'd0);

    // R4 one-shot parks at the limit, continuous runs past it
    wr(A_PLO, 32'd10); wr(A_PHI, 32'd0);
    wr(A_CLO, 32'd0);  wr(A_CHI, 32'd0);
    wr(A_TC, 32'h40);
    repeat (19) @(negedge clk);
    wr(A_TC, 32'd0);
    rd(A_CLO, v); chk("R4 one-shot parks", v, 32'd10);
    wr(A_CLO, 32'd0);
    wr(A_TC, 32'h80);
    repeat (19) @(negedge clk);
    wr(A_TC, 32'd0);
    rd(A_CLO, v); chk("R4 continuous passes", v, 32'd20);

    // R6 idle ignores stray control writes
    do_reset();
    wr(A_WC, RUN_EN);        chk("R6 lone run key no pulse", wd_rst, 1'b0);
    rd(A_WC, v);             chk("R6 lone run key ignored", v, 0);
    wr(A_WC, 32'hA5C6_0000); rd(A_WC, v); chk("R6 arm key without enable ignored", v, 0);
    wr(A_WC, 32'h0000_4000); rd(A_WC, v); chk("R6 junk key ignored", v, 0);
    chk("R6 no pulse in idle", wd_rst, 1'b0);

    // R5 arming; pre-active never expires even with limit 0
    setup(32'd0, 32'd0, 32'h80);
    wr(A_WC, ARM_EN);
    rd(A_WC, v); chk("R5 armed bit in pre-active", v, 32'h0000_4000);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 pre-active does not expire", wd_rst, 1'b0);
    end

    // R7 lock
    do_reset();
    setup(32'd3, 32'd0, 32'd0);
    wr(A_CLO, 32'd7);
    wr(A_WC, ARM_EN);
    wr(A_PLO, 32'h55); wr(A_CLO, 32'h99); wr(A_GC, 32'd0); wr(A_TC, 32'h80);
    rd(A_PLO, v); chk("R7 limit locked", v, 32'd3);
    rd(A_CLO, v); chk("R7 count locked", v, 32'd7);
    rd(A_GC, v);  chk("R7 global ctl locked", v, 32'h0B);
    rd(A_TC, v);  chk("R7 timer ctl locked", v, 32'd0);
    wr(A_WC, RUN_EN);
    rd(A_CLO, v); chk("R5 count cleared on activation", v, 32'd0);
    rd(A_WC, v);  chk("R5 armed bit in active", v, 32'h0000_4000);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R7 stopped counter never expires", wd_rst, 1'b0);
    end

    // R8 expiry timing sweep over small limits
    for (int p = 0; p < 8; p++) begin
      do_reset();
      setup(32'(p), 32'd0, 32'h80);
      wr(A_WC, ARM_EN);
      wr(A_WC, RUN_EN);
      chk("R8 no pulse at activation", wd_rst, 1'b0);
      for (int k = 1; k <= p + 2; k++) begin
        @(negedge clk);
        chk($sformatf("R8 limit %0d edge %0d", p, k), wd_rst, (k == p + 1) ? 1'b1 : 1'b0);
      end
      rd(A_WC, v); chk("R11 flag after expiry", v, 32'h0000_C000);
    end

    // R8 high half of the limit takes part
    do_reset();
    setup(32'd0, 32'd1, 32'h80);
    wr(A_WC, ARM_EN); wr(A_WC, RUN_EN);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R8 high limit half honoured", wd_rst, 1'b0);
    end

    // R9 service restarts the count
    do_reset();
    setup(32'd8, 32'd0, 32'h80);
    wr(A_WC, ARM_EN); wr(A_WC, RUN_EN);
    repeat (5) @(negedge clk);
    wr(A_WC, ARM_EN);
    chk("R9 no pulse entering service", wd_rst, 1'b0);
    wr(A_WC, RUN_EN);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk($sformatf("R9 after service edge %0d", k), wd_rst, (k == 9) ? 1'b1 : 1'b0);
    end

    // R10 / R11 key faults in every armed state
    for (int c = 0; c < 7; c++) bad_case(c);

    // R1 reset clears a fired block
    do_reset();
    rd(A_WC, v); chk("R1 reset clears flag", v, 0);
    rd(A_CLO, v); chk("R1 reset clears count", v, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule